// File: doc/BRIEF.md
# Device Interrupt Routing Controller

The controller keeps one routing entry for each interrupt-source device. An entry names the CPU that should receive the interrupt and the 6-bit vector to deliver, together with a mask flag and a pending flag. Software programs and inspects the entries through a small register port with valid, write, address and data signals. Every request on that port gets a registered response one cycle later, carrying read data or an error flag.

When a device line is high and its entry is unmasked, the controller accepts the interrupt. Acceptance sets the entry's mask and pending flags and places a request in an internal latch. A two-state arbiter then drains the latch one post per cycle, lowest source index first, and drives the (cpu, vector) pair of the granted entry on the delivery output. Each source produces exactly one post per arming. Software re-arms a source by writing 1 to the pending-clear bit and 0 to the mask bit.

The arbiter has two states. `ARB_IDLE` means no post is being driven. `ARB_SEND` means a post is on the output this cycle. It has four transitions. *grant* (`ARB_IDLE` to `ARB_SEND`) is taken when the latch holds a request. *wait* (`ARB_IDLE` to `ARB_IDLE`) is taken when the latch is empty. *chain* (`ARB_SEND` to `ARB_SEND`) is taken when another request is waiting. *drain* (`ARB_SEND` to `ARB_IDLE`) is taken when none is.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every entry reads cpu 0, vector 0, mask 1, pending 0, and no post is driven.
- R2: The routing word of entry i sits at byte offset 8*i, for offsets below 8*NUM_SRC. A write stores data bits 12:8 as the CPU and bits 5:0 as the vector. A read returns cpu<<8 | vector, with every other bit 0.
- R3: The control word of entry i sits at offset 8*NUM_SRC + 8*i. A write loads data bit 2 into mask. Data bit 1 set to 1 clears pending, and bit 1 set to 0 leaves pending alone. A read returns mask in bit 2 and pending in bit 0, with every other bit 0.
- R4: A device line that is high while its entry is masked is dropped: no post, and no change to mask or pending.
- R5: Suppose a line is high at a clock edge while its entry is unmasked. That edge sets the entry's mask and pending flags. If no other request waits, the next edge raises post_valid for one cycle, carrying the entry's current CPU and vector.
- R6: Simultaneously accepted interrupts are latched and posted one per cycle in ascending source index, on consecutive cycles.
- R7: An access whose offset has nonzero bits 2:0, or is at least 16*NUM_SRC, changes no state. Its response has rsp_err 1 and data 0.
- R8: Every accepted bus request produces exactly one response, with rsp_valid high in the cycle after the request. A cycle without a request produces no response. The data for a write is 0 and rsp_err is 0 for a mapped offset.
- R9: A device line held high for many cycles produces a single post until software re-arms its entry.
- R10: If a control write and an accepted interrupt hit the same entry in one cycle, the acceptance wins: mask and pending both end at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Device interrupt lines, one per source |
| bus_valid | input | 1 | Register request strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Unmapped-offset flag |
| rsp_rdata | output | DATA_W | Read data |
| post_valid | output | 1 | Interrupt post strobe |
| post_cpu | output | CPU_W | Target CPU of the post |
| post_vec | output | VEC_W | Vector of the post |

## Verification
The checks assume that irq_in, the bus inputs and rst_n change only away from the rising clock edge, and that no input is unknown outside reset. The pending-flag and acceptance checks also rely on a device line being sampled as a plain per-cycle level. The bench drives every input on the falling edge from a fixed-seed random stream, with all values fully defined. The random addresses mix aligned mapped offsets with arbitrary bytes, so both the decoder and the error path stay inside those limits. Directed sequences cover simultaneous firing, held levels, a write colliding with an acceptance, and misaligned or out-of-range offsets.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic [0:0] {
        ARB_IDLE = 1'b0,
        ARB_SEND = 1'b1
    } arb_state_e;

    localparam int unsigned MASK_BIT    = 2;
    localparam int unsigned CLR_BIT     = 1;
    localparam int unsigned PEND_BIT    = 0;
    localparam int unsigned CPU_LSB     = 8;
    localparam int unsigned VEC_LSB     = 0;
    localparam int unsigned ENTRY_SHIFT = 3;

endpackage

// File: rtl/irq_route_prio.sv
module irq_route_prio #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] pick
);

    always_comb begin
        any  = |req;
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int unsigned N      = 8,
    parameter int unsigned CPU_W  = 5,
    parameter int unsigned VEC_W  = 6,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IW     = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      irq_in,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [IW-1:0]     sel_idx,
    output logic [N-1:0]      accept,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [CPU_W-1:0]  sel_cpu,
    output logic [VEC_W-1:0]  sel_vec,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      pend_o
);

    localparam int unsigned REGION = N * (1 << ENTRY_SHIFT);
    localparam int unsigned SPAN   = 2 * REGION;

    logic [CPU_W-1:0]  cpu_q [N];
    logic [VEC_W-1:0]  vec_q [N];
    logic [N-1:0]      mask_q;
    logic [N-1:0]      pend_q;

    logic              aligned;
    logic              in_range;
    logic              hit;
    logic              is_ctl;
    logic [ADDR_W-1:0] off;
    logic [IW-1:0]     idx;
    logic              do_wr;
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        aligned  = (bus_addr[ENTRY_SHIFT-1:0] == '0);
        in_range = (32'(bus_addr) < 32'(SPAN));
        hit      = aligned && in_range;
        is_ctl   = (32'(bus_addr) >= 32'(REGION));
        off      = is_ctl ? ADDR_W'(32'(bus_addr) - 32'(REGION)) : bus_addr;
        idx      = off[ENTRY_SHIFT +: IW];
        do_wr    = bus_valid && bus_write && hit;
        if (is_ctl) begin
            rd_word = '0;
            rd_word[MASK_BIT] = mask_q[idx];
            rd_word[PEND_BIT] = pend_q[idx];
        end else begin
            rd_word = (DATA_W'(cpu_q[idx]) << CPU_LSB) | (DATA_W'(vec_q[idx]) << VEC_LSB);
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_accept
        assign accept[g] = irq_in[g] & ~mask_q[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                cpu_q[i] <= '0;
                vec_q[i] <= '0;
            end
            mask_q <= '1;
            pend_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (do_wr && !is_ctl && (idx == IW'(i))) begin
                    cpu_q[i] <= bus_wdata[CPU_LSB +: CPU_W];
                    vec_q[i] <= bus_wdata[VEC_LSB +: VEC_W];
                end
                if (accept[i]) begin
                    mask_q[i] <= 1'b1;
                    pend_q[i] <= 1'b1;
                end else if (do_wr && is_ctl && (idx == IW'(i))) begin
                    mask_q[i] <= bus_wdata[MASK_BIT];
                    if (bus_wdata[CLR_BIT]) begin
                        pend_q[i] <= 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= bus_valid;
            rsp_err   <= bus_valid && !hit;
            rsp_rdata <= (bus_valid && !bus_write && hit) ? rd_word : '0;
        end
    end

    assign sel_cpu = cpu_q[sel_idx];
    assign sel_vec = vec_q[sel_idx];
    assign mask_o  = mask_q;
    assign pend_o  = pend_q;

endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb
    import irq_route_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  accept,
    output logic          post_valid,
    output logic [IW-1:0] gnt_idx
);

    arb_state_e    state_q;
    arb_state_e    state_d;
    logic [N-1:0]  req_q;
    logic [N-1:0]  clr;
    logic [IW-1:0] gnt_q;
    logic          any;
    logic [IW-1:0] pick;

    irq_route_prio #(.N(N), .IW(IW)) u_prio (
        .req  (req_q),
        .any  (any),
        .pick (pick)
    );

    always_comb begin
        clr = '0;
        if (any) begin
            clr[pick] = 1'b1;
        end
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: state_d = any ? ARB_SEND : ARB_IDLE;   // grant / wait
            ARB_SEND: state_d = any ? ARB_SEND : ARB_IDLE;   // chain / drain
            default:  state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            req_q   <= '0;
            gnt_q   <= '0;
        end else begin
            state_q <= state_d;
            req_q   <= (req_q & ~clr) | accept;
            if (any) begin
                gnt_q <= pick;
            end
        end
    end

    always_comb begin
        post_valid = (state_q == ARB_SEND);
        gnt_idx    = gnt_q;
    end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned CPU_W   = 5,
    parameter int unsigned VEC_W   = 6,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               post_valid,
    output logic [CPU_W-1:0]   post_cpu,
    output logic [VEC_W-1:0]   post_vec
);

    localparam int unsigned IW = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] accept;
    logic [IW-1:0]      gnt_idx;
    logic [NUM_SRC-1:0] src_mask;
    logic [NUM_SRC-1:0] src_pend;

    irq_route_table #(
        .N(NUM_SRC), .CPU_W(CPU_W), .VEC_W(VEC_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IW(IW)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sel_idx   (gnt_idx),
        .accept    (accept),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .sel_cpu   (post_cpu),
        .sel_vec   (post_vec),
        .mask_o    (src_mask),
        .pend_o    (src_pend)
    );

    irq_route_arb #(.N(NUM_SRC), .IW(IW)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .post_valid (post_valid),
        .gnt_idx    (gnt_idx)
    );

endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk #(
    parameter int unsigned N      = 8,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      irq_in,
    input logic              bus_valid,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [N-1:0]      mask,
    input logic [N-1:0]      pend
);

    // R8
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> rsp_valid);

    // R8
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !rsp_valid);

    // R7
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    for (genvar g = 0; g < N; g++) begin : g_src
        // R5
        accept_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_in[g] && !mask[g]) |=> (mask[g] && pend[g]));

        // R4
        pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend[g] && !(irq_in[g] && !mask[g])) |=> !pend[g]);
    end

endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(.N(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_valid (bus_valid),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .mask      (src_mask),
    .pend      (src_pend)
);

// File: tb/irq_route_ctrl_bench.sv
`timescale 1ns/1ps
module irq_route_ctrl_bench;

    localparam int N      = 8;
    localparam int CPU_W  = 5;
    localparam int VEC_W  = 6;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      irq = '0;
    logic              bv = 1'b0;
    logic              bw = 1'b0;
    logic [ADDR_W-1:0] ba = '0;
    logic [DATA_W-1:0] bd = '0;
    logic              rsp_valid, rsp_err, post_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic [CPU_W-1:0]  post_cpu;
    logic [VEC_W-1:0]  post_vec;

    always #2.5 clk = ~clk;

    irq_route_ctrl #(.NUM_SRC(N), .CPU_W(CPU_W), .VEC_W(VEC_W),
                     .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_irq_route_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq),
        .bus_valid(bv), .bus_write(bw), .bus_addr(ba), .bus_wdata(bd),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
    );

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;
    int cyc_cnt  = 0;

    int m_cpu [N];
    int m_vec [N];
    bit m_mask [N];
    bit m_pend [N];
    bit m_req  [N];

    bit e_rv, e_err, e_pv;
    int e_rd, e_g;
    string rd_tag;
    string cur_tag  = "";
    string post_tag = "R6";

    function automatic bit hit_f(logic [ADDR_W-1:0] a);
        return (a[2:0] == 3'd0) && (int'(a) < 16 * N);
    endfunction

    function automatic int rd_f(logic [ADDR_W-1:0] a);
        int i;
        if (int'(a) >= 8 * N) begin
            i = (int'(a) - 8 * N) >> 3;
            return (int'(m_mask[i]) << 2) | int'(m_pend[i]);
        end
        i = int'(a) >> 3;
        return (m_cpu[i] << 8) | m_vec[i];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_cpu[i] = 0; m_vec[i] = 0; m_mask[i] = 1; m_pend[i] = 0; m_req[i] = 0;
        end
    endtask

    task automatic model_edge();
        int g;
        bit acc [N];
        int i;
        g = -1;
        for (int k = N - 1; k >= 0; k--) if (m_req[k]) g = k;
        for (int k = 0; k < N; k++) acc[k] = irq[k] && !m_mask[k];
        e_rv  = bv;
        e_err = bv && !hit_f(ba);
        e_rd  = (bv && !bw && hit_f(ba)) ? rd_f(ba) : 0;
        if (!bv) rd_tag = "R8";
        else if (!hit_f(ba)) rd_tag = "R7";
        else if (bw) rd_tag = "R8";
        else if (int'(ba) >= 8 * N) rd_tag = "R3";
        else rd_tag = "R2";
        if (bv && bw && hit_f(ba)) begin
            if (int'(ba) >= 8 * N) begin
                i = (int'(ba) - 8 * N) >> 3;
                m_mask[i] = bd[2];
                if (bd[1]) m_pend[i] = 0;
            end else begin
                i = int'(ba) >> 3;
                m_cpu[i] = int'(bd[12:8]);
                m_vec[i] = int'(bd[5:0]);
            end
        end
        for (int k = 0; k < N; k++) if (acc[k]) begin m_mask[k] = 1; m_pend[k] = 1; end
        e_pv = (g >= 0);
        if (g >= 0) begin e_g = g; m_req[g] = 0; end
        for (int k = 0; k < N; k++) if (acc[k]) m_req[k] = 1;
    endtask

    task automatic chk(string tag, int got, int exp, string what);
        n_checks++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic compare();
        string t;
        chk("R8", int'(rsp_valid), int'(e_rv), "rsp_valid");
        chk(e_err ? "R7" : "R8", int'(rsp_err), int'(e_err), "rsp_err");
        t = (cur_tag != "") ? cur_tag : rd_tag;
        chk(t, int'(rsp_rdata), e_rd, "rsp_rdata");
        chk(post_tag, int'(post_valid), int'(e_pv), "post_valid");
        if (e_pv && post_valid) begin
            chk(post_tag, int'(post_cpu), m_cpu[e_g], "post_cpu");
            chk(post_tag, int'(post_vec), m_vec[e_g], "post_vec");
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic bus(bit w, int a, int d);
        bv = 1'b1; bw = w; ba = ADDR_W'(a); bd = DATA_W'(d);
        cyc();
        bv = 1'b0; bw = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000 && !done) begin
            n_checks++;
            n_err++;
            $display("FAIL R8 watchdog: got %0d cycles expected under 100000", cyc_cnt);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state: no post, entries at reset values
        chk("R1", int'(post_valid), 0, "post_valid after reset");
        cur_tag = "R1"; post_tag = "R1";
        for (int i = 0; i < 2 * N; i++) bus(0, i * 8, 0);
        cur_tag = ""; post_tag = "R6";

        // R2 routing word write with stray bits, read back
        bus(1, 3 * 8, 16'hFFFF);
        bus(0, 3 * 8, 0);
        bus(1, 3 * 8, 16'h152A);
        bus(0, 3 * 8, 0);

        // R4 masked line dropped
        post_tag = "R4";
        irq = 8'h08; cyc(); irq = '0;
        idle(3);
        bus(0, 8 * N + 3 * 8, 0);
        post_tag = "R6";

        // R5 unmask entry 3 then fire
        post_tag = "R5";
        bus(1, 8 * N + 3 * 8, 16'h0002);
        irq = 8'h08; cyc(); irq = '0;
        idle(3);
        bus(0, 8 * N + 3 * 8, 0);
        post_tag = "R6";

        // R6 simultaneous firing on 5, 2, 1
        bus(1, 1 * 8, 16'h0111);
        bus(1, 2 * 8, 16'h0222);
        bus(1, 5 * 8, 16'h0535);
        bus(1, 8 * N + 1 * 8, 16'h0002);
        bus(1, 8 * N + 2 * 8, 16'h0002);
        bus(1, 8 * N + 5 * 8, 16'h0002);
        irq = 8'h26; cyc(); irq = '0;
        idle(5);

        // R9 held level posts once
        post_tag = "R9";
        bus(1, 8 * N + 6 * 8, 16'h0002);
        irq = 8'h40;
        idle(20);
        irq = '0;
        idle(2);
        post_tag = "R6";

        // R10 control write colliding with acceptance on entry 0
        bus(1, 8 * N, 16'h0002);
        cur_tag = "R10"; post_tag = "R10";
        irq = 8'h01;
        bus(1, 8 * N, 16'h0002);
        irq = '0;
        idle(2);
        bus(0, 8 * N, 0);
        cur_tag = ""; post_tag = "R6";

        // R7 misaligned and out-of-range accesses leave state untouched
        bus(1, 8 * N + 4, 16'h0002);
        bus(1, 16 * N + 8, 16'hFFFF);
        bus(0, 8 * N + 1, 0);
        cur_tag = "R7";
        bus(0, 8 * N, 0);
        bus(0, 0, 0);
        cur_tag = "";

        // random mix
        for (int c = 0; c < 4000; c++) begin
            int r;
            irq = N'($urandom & $urandom & $urandom);
            r = $urandom % 4;
            bv = (r != 0);
            bw = $urandom % 2;
            if ($urandom % 8 == 0) ba = ADDR_W'($urandom);
            else ba = ADDR_W'(($urandom % (2 * N)) * 8);
            bd = DATA_W'($urandom);
            if ($urandom % 2 == 0) bd[2] = 1'b0;
            cyc();
        end
        irq = '0; bv = 1'b0;
        idle(N + 2);
        for (int i = 0; i < 2 * N; i++) bus(0, i * 8, 0);

        finish_run();
    end

endmodule